// File: doc/BRIEF.md
# Low-Speed Field Duty Rate Limiter

This block sits between the analog voltage loop of an alternator field regulator and the field PWM generator. At low engine speed it stops the field duty from rising faster than a slow, fixed rate. A sudden accessory load therefore cannot put a step of torque on the engine. A trailing up/down counter follows the duty demanded by the analog loop, but only moves one LSB per divided period tick. The duty sent on is the lower of the counter and the demand, so a fall in demand always takes effect at once.

Engine speed is judged from the stator phase signal. Rising edges are counted over a fixed window of prescaler ticks and the count is compared with a threshold that has one count of hysteresis. Above the threshold the limiter steps aside and the demand passes through unchanged. While it is bypassed, the counter tracks the demand, so the hand-back is bumpless when speed falls again.

Top module: `load_rate_limiter`

## Requirements
- R1: While `rst` is high, and after it is released until the first counter step, the trailing counter is 0 and `limit_on` is 1. So `duty_out` reads 0 whatever `demand` is.
- R2: When `limit_on` is 0, `duty_out` equals `demand` in the same cycle.
- R3: The trailing counter can change only on a divided tick. With `rate_sel` = 0 this is every 12th `tick`. With `rate_sel` = 1 it is every 48th `tick`. Counting starts from reset and restarts after each divided tick.
- R4: When `limit_on` is 1, `duty_out` is the smaller of the trailing counter and `demand`. `duty_out` never exceeds `demand`.
- R5: On a divided tick while active, the counter rises by one if `demand` is above it, falls by one if `demand` is below it, and holds if they are equal. It never wraps past 0 or 255.
- R6: A rising edge of `phase_in` is counted once. Edges are counted over windows of 256 `tick`s. At the end of a window, a count above THRESH (default 20) clears `limit_on`, and a count below THRESH sets it. A count equal to THRESH leaves it unchanged. `limit_on` changes at no other time.
- R7: While `limit_on` is 0, the counter loads `demand` every clock. When the block becomes active again, `duty_out` starts from the demand of that moment.
- R8: In a cycle with `tick` low, neither the window, the divider nor the trailing counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Regulator clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| tick | input | 1 | One-cycle pulse per PWM period from the prescaler |
| rate_sel | input | 1 | 0: step every 12 ticks, 1: step every 48 ticks |
| phase_in | input | 1 | Stator phase pulse, synchronous to `clk` |
| demand | input | 8 | Duty code from the analog loop (0 off, 255 full) |
| duty_out | output | 8 | Limited duty code to the PWM generator |
| limit_on | output | 1 | High while the low-speed limiting is active |

## Verification
The assertions assume that `phase_in` and `tick` are already synchronous to `clk` and free of glitches, and that `demand` may change on any cycle. The stimulus drives every input on the falling edge only. It gives `phase_in` periods of at least two clocks, so each pulse is seen. It runs edge rates below, at and above the threshold, and with `tick` both continuous and gapped, so that window ends and divided ticks fall on many different demand values.

// File: rtl/load_rate_limiter.sv
module load_rate_limiter #(
  parameter int DW       = 8,
  parameter int WIN      = 256,
  parameter int THRESH   = 20,
  parameter int DIV_FAST = 12,
  parameter int DIV_SLOW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rate_sel,
  input  logic          phase_in,
  input  logic [DW-1:0] demand,
  output logic [DW-1:0] duty_out,
  output logic          limit_on
);
  localparam int WW = $clog2(WIN);
  localparam int EW = $clog2(THRESH + 2);
  localparam int VW = $clog2(DIV_SLOW);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);
  localparam logic [EW-1:0] EDGE_SAT = EW'(THRESH + 1);
  localparam logic [EW:0]   THR      = (EW+1)'(THRESH);

  logic          phase_q;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic [VW-1:0] div_cnt;
  logic [DW-1:0] trail;

  wire           edge_det   = phase_in & ~phase_q;
  wire           win_end    = tick && (win_cnt == WIN_LAST);
  wire [EW:0]    edge_total = {1'b0, edge_cnt} + (EW+1)'(edge_det);
  wire [VW-1:0]  div_last   = rate_sel ? VW'(DIV_SLOW - 1) : VW'(DIV_FAST - 1);
  wire           step       = tick && (div_cnt >= div_last);

  assign duty_out = (limit_on && trail < demand) ? trail : demand;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      win_cnt  <= '0;
      edge_cnt <= '0;
      limit_on <= 1'b1;
    end else begin
      phase_q <= phase_in;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= '0;
        if (edge_total > THR)      limit_on <= 1'b0;
        else if (edge_total < THR) limit_on <= 1'b1;
      end else begin
        if (tick) win_cnt <= win_cnt + 1'b1;
        if (edge_det && edge_cnt != EDGE_SAT) edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      trail   <= '0;
    end else begin
      if (tick) div_cnt <= step ? '0 : div_cnt + 1'b1;
      if (!limit_on)                  trail <= demand;
      else if (step && demand > trail) trail <= trail + 1'b1;
      else if (step && demand < trail) trail <= trail - 1'b1;
    end
  end

  a_r4_not_above: assert property (@(posedge clk) disable iff (rst)
    duty_out <= demand);

  a_r5_one_lsb: assert property (@(posedge clk) disable iff (rst)
    limit_on |=> (trail == $past(trail)) || (trail == $past(trail) + 1'b1)
                 || (trail == $past(trail) - 1'b1));

  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (limit_on && !tick) |=> $stable(trail));

  a_r6_flag_at_window_end: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(limit_on));

  a_r3_fast_rate_gap: assert property (@(posedge clk) disable iff (rst)
    (limit_on && tick && !rate_sel && div_cnt < VW'(DIV_FAST - 1)) |=> $stable(trail));
endmodule

// File: tb/sim_load_rate_limiter.sv
`timescale 1ns/1ps
module sim_load_rate_limiter;
  localparam int TH = 20;
  logic clk = 0, rst = 1, tick = 0, rate_sel = 0, phase_in = 0;
  logic [7:0] demand = 0;
  logic [7:0] duty_out;
  logic limit_on;
  int checks = 0, fails = 0;
  bit done = 0;

  load_rate_limiter u0 (.clk(clk), .rst(rst), .tick(tick), .rate_sel(rate_sel),
    .phase_in(phase_in), .demand(demand), .duty_out(duty_out), .limit_on(limit_on));

  always #2 clk = ~clk;

  int m_trail, m_win, m_edges, m_div, m_prev;
  bit m_act;
  always @(posedge clk) begin
    int n; bit ed, step, old;
    if (rst) begin
      m_trail = 0; m_act = 1; m_win = 0; m_edges = 0; m_div = 0; m_prev = 0;
    end else begin
      ed = phase_in && !m_prev; m_prev = phase_in; old = m_act;
      if (tick && m_win == 255) begin
        if (m_edges + ed > TH) m_act = 0;
        else if (m_edges + ed < TH) m_act = 1;
        m_win = 0; m_edges = 0;
      end else begin
        if (tick) m_win++;
        m_edges += ed;
      end
      n = rate_sel ? 48 : 12; step = 0;
      if (tick) begin
        if (m_div >= n - 1) begin m_div = 0; step = 1; end else m_div++;
      end
      if (!old) m_trail = demand;
      else if (step && demand > m_trail) m_trail++;
      else if (step && demand < m_trail) m_trail--;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      int e;
      e = (m_act && m_trail < demand) ? m_trail : demand;
      check("R6 flag", limit_on, m_act);
      check(m_act ? "R4 limited duty" : "R2 bypass duty", duty_out, e);
    end
  end

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      for (int g = 0; g < gap; g++) @(negedge clk) tick = 0;
    end
    @(negedge clk) tick = 0;
  endtask

  task automatic run_phase(int cycles, int half);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      tick = 1;
      if (i % half == 0) phase_in = ~phase_in;
    end
    @(negedge clk) tick = 0; phase_in = 0;
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    demand = 200;
    repeat (3) @(negedge clk);
    check("R1 duty in reset", duty_out, 0);
    rst = 0;
    @(negedge clk);
    check("R1 duty after reset", duty_out, 0);
    check("R1 flag after reset", limit_on, 1);
    ticks(11, 0);
    check("R3 no step before 12th tick", duty_out, 0);
    ticks(1, 0);
    check("R3 step on 12th tick", duty_out, 1);
    rate_sel = 1;
    ticks(47, 0);
    check("R3 no step before 48th tick", duty_out, 1);
    ticks(1, 0);
    check("R3 step on 48th tick", duty_out, 2);
    ticks(30, 3);
    check("R8 gapped ticks still ramp", duty_out, 2);
    rate_sel = 0;
    ticks(600, 0);
    demand = 0;
    @(negedge clk);
    check("R4 drop passes at once", duty_out, 0);
    ticks(200, 1);
    demand = 255;
    ticks(255 * 12 + 300, 0);
    check("R5 saturates at 255", duty_out, 255);
    demand = 40;
    ticks(300, 0);
    check("R5 walks down to demand", duty_out, 40);
    demand = 90;
    run_phase(600, 2);
    check("R6 high speed clears flag", limit_on, 0);
    demand = 170;
    @(negedge clk);
    check("R2 bypass follows demand", duty_out, 170);
    run_phase(800, 13);
    run_phase(800, 12);
    run_phase(800, 6);
    demand = 150;
    run_phase(700, 40);
    check("R6 low speed sets flag", limit_on, 1);
    check("R7 resumes from demand", duty_out, 150);
    demand = 220;
    rate_sel = 1;
    ticks(500, 2);
    run_phase(1500, 12);
    ticks(400, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule